// File: doc/BRIEF.md
# Clock-Driver Power-Mode Controller

This block is the control plane of a fan-out clock buffer built around a phase-locked loop. It watches a power-down pin, a PLL-bypass strap, the PLL lock flag and the incoming differential reference pair. From these it picks one of four operating modes. In each mode it drives the PLL enable, the input receiver enable and the bypass mux select. It also drives the output-enable and output data of every differential output pair and of the feedback pair. The analog PLL and the I/O cells are outside the block. The PLL appears only as an enable, a lock flag and its recovered clock pair.

An input-frequency detector runs from the reference clock and counts rising edges of the raw input clock over a fixed window. It does not depend on the receiver enable. When the count falls under an entry threshold, the block tri-states everything and stops the PLL. When the count climbs to an exit threshold, the block returns to normal operation with no software involved. The gap between the two thresholds gives hysteresis. After the PLL is switched on, a lock-wait timer must expire before a locked status is reported.

The four states are ST_ON (code 00), ST_BYP (01), ST_PD (10) and ST_LP (11). Every transition is made directly to the state picked by precedence:
- PD_ENTER: any state moves to ST_PD when the synchronized power-down pin is low.
- BYP_ENTER: otherwise, any state moves to ST_BYP when the synchronized strap is high.
- LP_ENTER: otherwise, any state moves to ST_LP when the detector flags a low frequency.
- ON_ENTER: otherwise, any state moves to ST_ON.

Top module: `clkdrv_pwr_ctrl`

## Requirements
- R1: While the power-down pin `pd_n` is low, the mode goes to 10 (three reference edges after the pin is sampled). This holds whatever the strap or frequency. In mode 10, `pll_en_o` and `rx_en_o` are 0, every `out_oe_o` bit is 0 and `fb_oe_o` is 0.
- R2: With `pd_n` high and `byp_strap` high, the mode is 01, whatever the input frequency. `pll_en_o` is 0, `rx_en_o` and `byp_sel_o` are 1 and all enables are 1. Every `out_t_o` bit and `fb_t_o` equal `in_clk_t`, and every `out_c_o` bit and `fb_c_o` equal `in_clk_c`.
- R3: With `pd_n` high and the strap low, a window of WIN reference cycles with fewer than ENTER_EDGES input rising edges puts the mode at 11. In mode 11, PLL, receivers and all enables are off, as in mode 10.
- R4: From mode 11, a window with at least EXIT_EDGES input edges returns the mode to 00, with `pll_en_o`, `rx_en_o` and all enables at 1. The detector keeps counting while the receivers are disabled.
- R5: A window count from ENTER_EDGES up to EXIT_EDGES-1 leaves the low-frequency decision unchanged. Mode 00 stays 00 and mode 11 stays 11.
- R6: In mode 00, `byp_sel_o` is 0. Every `out_t_o` bit and `fb_t_o` follow `pll_clk_t`, and every `out_c_o` bit and `fb_c_o` follow `pll_clk_c`.
- R7: `locked_o` rises exactly LOCK_WAIT reference edges after the mode enters 00, and only while `pll_lock` is 1. It is 0 whenever `pll_lock` is 0.
- R8: Any exit from mode 00 clears `locked_o`. On re-entry the wait restarts, so `locked_o` is 0 in the first cycle back in mode 00.
- R9: After reset the mode is 10, `locked_o` is 0 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_clk_t | input | 1 | True leg of the input clock pair |
| in_clk_c | input | 1 | Complement leg of the input clock pair |
| pd_n | input | 1 | Power-down pin, low powers down |
| byp_strap | input | 1 | PLL-bypass test strap, high bypasses |
| pll_lock | input | 1 | Lock flag from the PLL |
| pll_clk_t | input | 1 | True leg of the PLL output clock |
| pll_clk_c | input | 1 | Complement leg of the PLL output clock |
| pll_en_o | output | 1 | PLL enable |
| rx_en_o | output | 1 | Input receiver enable |
| byp_sel_o | output | 1 | Output mux select, 1 routes the input pair |
| out_t_o | output | NUM_OUT | True legs of the output pairs |
| out_c_o | output | NUM_OUT | Complement legs of the output pairs |
| out_oe_o | output | NUM_OUT | Per-pair output enable, 0 is high impedance |
| fb_t_o | output | 1 | True leg of the feedback pair |
| fb_c_o | output | 1 | Complement leg of the feedback pair |
| fb_oe_o | output | 1 | Feedback pair output enable |
| mode_o | output | 2 | Mode: 00 on, 01 bypass, 10 power-down, 11 low-power |
| locked_o | output | 1 | PLL lock valid after the wait interval |

## Verification
On every cycle, the assertions check several rules. A low power-down pin forces mode 10 three edges later. Power-down and low-power modes keep the PLL, receivers and drivers off. Bypass mode routes each input leg to the matching output legs. `locked_o` is never high outside mode 00 or without `pll_lock`, and never high in the first cycle of a fresh entry into mode 00. Some behaviour only the bench scenarios can show: that three input rates land below, between and above the two thresholds with the expected effect, that the lock wait lasts exactly LOCK_WAIT edges, and that a clock returning during low-power mode brings the block back on.

// File: rtl/clkdrv_pkg.sv
package clkdrv_pkg;

    typedef enum logic [1:0] {
        ST_ON  = 2'b00,
        ST_BYP = 2'b01,
        ST_PD  = 2'b10,
        ST_LP  = 2'b11
    } drv_mode_e;

endpackage

// File: rtl/clkdrv_sync.sv
module clkdrv_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/clkdrv_freq_det.sv
module clkdrv_freq_det #(
    parameter int WIN         = 64,
    parameter int ENTER_EDGES = 11,
    parameter int EXIT_EDGES  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_clk_i,
    output logic low_freq_o
);

    localparam int CW = $clog2(WIN + 1);
    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);
    localparam logic [CW-1:0] ENTER_C  = CW'(ENTER_EDGES);
    localparam logic [CW-1:0] EXIT_C   = CW'(EXIT_EDGES);
    localparam logic [CW-1:0] CNT_MAX  = CW'(WIN);

    logic          in_s;
    logic          in_prev_q;
    logic          rise;
    logic [WW-1:0] win_q;
    logic [CW-1:0] edge_q;
    logic [CW-1:0] edge_tot;
    logic          low_q;

    clkdrv_sync #(.WIDTH(1)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (in_clk_i),
        .q_o   (in_s)
    );

    assign rise     = in_s & ~in_prev_q;
    assign edge_tot = (rise && edge_q != CNT_MAX) ? edge_q + 1'b1 : edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_prev_q <= 1'b0;
            win_q     <= '0;
            edge_q    <= '0;
            low_q     <= 1'b1;
        end else begin
            in_prev_q <= in_s;
            if (win_q == WIN_LAST) begin
                win_q  <= '0;
                edge_q <= '0;
                if (!low_q && edge_tot < ENTER_C)
                    low_q <= 1'b1;
                else if (low_q && edge_tot >= EXIT_C)
                    low_q <= 1'b0;
            end else begin
                win_q  <= win_q + 1'b1;
                edge_q <= edge_tot;
            end
        end
    end

    assign low_freq_o = low_q;

endmodule

// File: rtl/clkdrv_lock_timer.sv
module clkdrv_lock_timer #(
    parameter int LOCK_WAIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int LW = $clog2(LOCK_WAIT + 1);
    localparam logic [LW-1:0] LIMIT = LW'(LOCK_WAIT);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == LIMIT);

endmodule

// File: rtl/clkdrv_pwr_ctrl.sv
module clkdrv_pwr_ctrl #(
    parameter int NUM_OUT     = 10,
    parameter int WIN         = 64,
    parameter int ENTER_EDGES = 11,
    parameter int EXIT_EDGES  = 15,
    parameter int LOCK_WAIT   = 10000
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               in_clk_t,
    input  logic               in_clk_c,
    input  logic               pd_n,
    input  logic               byp_strap,
    input  logic               pll_lock,
    input  logic               pll_clk_t,
    input  logic               pll_clk_c,
    output logic               pll_en_o,
    output logic               rx_en_o,
    output logic               byp_sel_o,
    output logic [NUM_OUT-1:0] out_t_o,
    output logic [NUM_OUT-1:0] out_c_o,
    output logic [NUM_OUT-1:0] out_oe_o,
    output logic               fb_t_o,
    output logic               fb_c_o,
    output logic               fb_oe_o,
    output logic [1:0]         mode_o,
    output logic               locked_o
);

    import clkdrv_pkg::*;

    drv_mode_e state_q;
    drv_mode_e state_nxt;
    logic [1:0] pin_s;
    logic       pd_n_s;
    logic       byp_s;
    logic       low_freq;
    logic       wait_done;
    logic       drive_en;
    logic       src_t;
    logic       src_c;

    clkdrv_sync #(.WIDTH(2)) u_pin_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d_i   ({pd_n, byp_strap}),
        .q_o   (pin_s)
    );
    assign pd_n_s = pin_s[1];
    assign byp_s  = pin_s[0];

    clkdrv_freq_det #(
        .WIN         (WIN),
        .ENTER_EDGES (ENTER_EDGES),
        .EXIT_EDGES  (EXIT_EDGES)
    ) u_freq_det (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .in_clk_i   (in_clk_t),
        .low_freq_o (low_freq)
    );

    // Next state by fixed precedence.
    always_comb begin
        if (!pd_n_s)
            state_nxt = ST_PD;
        else if (byp_s)
            state_nxt = ST_BYP;
        else if (low_freq)
            state_nxt = ST_LP;
        else
            state_nxt = ST_ON;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_PD;
        else
            state_q <= state_nxt;
    end

    clkdrv_lock_timer #(.LOCK_WAIT(LOCK_WAIT)) u_lock_timer (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_ON),
        .done_o (wait_done)
    );

    // Control decode per state.
    always_comb begin
        pll_en_o  = 1'b0;
        rx_en_o   = 1'b0;
        byp_sel_o = 1'b0;
        drive_en  = 1'b0;
        locked_o  = 1'b0;
        unique case (state_q)
            ST_ON: begin
                pll_en_o = 1'b1;
                rx_en_o  = 1'b1;
                drive_en = 1'b1;
                locked_o = wait_done & pll_lock;
            end
            ST_BYP: begin
                rx_en_o   = 1'b1;
                byp_sel_o = 1'b1;
                drive_en  = 1'b1;
            end
            ST_PD: ;
            ST_LP: ;
        endcase
    end

    assign src_t = drive_en & (byp_sel_o ? in_clk_t : pll_clk_t);
    assign src_c = drive_en & (byp_sel_o ? in_clk_c : pll_clk_c);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
        assign out_t_o[g]  = src_t;
        assign out_c_o[g]  = src_c;
        assign out_oe_o[g] = drive_en;
    end

    assign fb_t_o  = src_t;
    assign fb_c_o  = src_c;
    assign fb_oe_o = drive_en;
    assign mode_o  = state_q;

endmodule

// File: rtl/clkdrv_pwr_ctrl_chk.sv
module clkdrv_pwr_ctrl_chk #(
    parameter int NUM_OUT = 10
) (
    input logic               clk_ref,
    input logic               rst_n,
    input logic               in_clk_t,
    input logic               in_clk_c,
    input logic               pd_n,
    input logic               pll_lock,
    input logic               pll_en_o,
    input logic               rx_en_o,
    input logic [NUM_OUT-1:0] out_t_o,
    input logic [NUM_OUT-1:0] out_c_o,
    input logic [NUM_OUT-1:0] out_oe_o,
    input logic               fb_t_o,
    input logic               fb_c_o,
    input logic               fb_oe_o,
    input logic [1:0]         mode_o,
    input logic               locked_o
);

    p_pin_forces_pd_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$past(pd_n, 3) |-> mode_o == 2'b10);

    p_pd_quiet_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        mode_o == 2'b10 |-> (!pll_en_o && !rx_en_o && out_oe_o == '0 && !fb_oe_o));

    p_byp_route_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        mode_o == 2'b01 |-> (!pll_en_o && out_t_o == {NUM_OUT{in_clk_t}}
                             && out_c_o == {NUM_OUT{in_clk_c}}
                             && fb_t_o == in_clk_t && fb_c_o == in_clk_c));

    p_lp_quiet_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        mode_o == 2'b11 |-> (!pll_en_o && !rx_en_o && out_oe_o == '0 && !fb_oe_o));

    p_locked_valid_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        locked_o |-> (pll_lock && mode_o == 2'b00));

    p_locked_restart_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(mode_o) != 2'b00 |-> !locked_o);

endmodule

bind clkdrv_pwr_ctrl clkdrv_pwr_ctrl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .in_clk_t (in_clk_t),
    .in_clk_c (in_clk_c),
    .pd_n     (pd_n),
    .pll_lock (pll_lock),
    .pll_en_o (pll_en_o),
    .rx_en_o  (rx_en_o),
    .out_t_o  (out_t_o),
    .out_c_o  (out_c_o),
    .out_oe_o (out_oe_o),
    .fb_t_o   (fb_t_o),
    .fb_c_o   (fb_c_o),
    .fb_oe_o  (fb_oe_o),
    .mode_o   (mode_o),
    .locked_o (locked_o)
);

// File: tb/clkdrv_pwr_ctrl_tb.sv
module clkdrv_pwr_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_OUT    = 10;
    localparam int WIN        = 64;
    localparam int ENTER      = 6;
    localparam int EXIT       = 10;
    localparam int LOCK_WAIT  = 100;
    localparam int SETTLE     = 3 * WIN + 10;

    logic clk_ref = 1'b0;
    logic rst_n   = 1'b0;
    logic in_t    = 1'b0;
    logic in_c    = 1'b1;
    logic pd_n    = 1'b0;
    logic strap   = 1'b0;
    logic lock    = 1'b1;
    logic pclk_t  = 1'b0;
    logic pclk_c  = 1'b1;
    logic run_in  = 1'b1;
    int   half_ns = 20;

    logic               pll_en, rx_en, byp_sel, fb_t, fb_c, fb_oe, locked;
    logic [NUM_OUT-1:0] out_t, out_c, out_oe;
    logic [1:0]         mode;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

    always begin
        if (run_in) begin
            #(half_ns);
            if (run_in) begin
                in_t = ~in_t;
                in_c = ~in_t;
            end
        end else begin
            #(CLK_PERIOD);
        end
    end

    clkdrv_pwr_ctrl #(
        .NUM_OUT     (NUM_OUT),
        .WIN         (WIN),
        .ENTER_EDGES (ENTER),
        .EXIT_EDGES  (EXIT),
        .LOCK_WAIT   (LOCK_WAIT)
    ) u_dut (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .in_clk_t  (in_t),
        .in_clk_c  (in_c),
        .pd_n      (pd_n),
        .byp_strap (strap),
        .pll_lock  (lock),
        .pll_clk_t (pclk_t),
        .pll_clk_c (pclk_c),
        .pll_en_o  (pll_en),
        .rx_en_o   (rx_en),
        .byp_sel_o (byp_sel),
        .out_t_o   (out_t),
        .out_c_o   (out_c),
        .out_oe_o  (out_oe),
        .fb_t_o    (fb_t),
        .fb_c_o    (fb_c),
        .fb_oe_o   (fb_oe),
        .mode_o    (mode),
        .locked_o  (locked)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    function automatic logic [3:0] ctl();
        return {pll_en, rx_en, &out_oe, fb_oe};
    endfunction

    task automatic t_reset();
        tick(2);
        check("R9 mode", mode, 2'b10);
        check("R9 locked", locked, 1'b0);
        check("R9 enables", {ctl(), |out_oe}, 5'b0);
        rst_n = 1'b1;
        tick(SETTLE);
        check("R1 pd held mode", mode, 2'b10);
        check("R1 pd controls", {ctl(), |out_oe}, 5'b0);
    endtask

    task automatic t_lock_wait();
        int guard = 0;
        pd_n = 1'b1;
        do begin
            tick(1);
            guard++;
        end while (mode != 2'b00 && guard < 50);
        check("R4 on from pd", mode, 2'b00);
        check("R8 not locked at entry", locked, 1'b0);
        tick(LOCK_WAIT - 1);
        check("R7 not yet locked", locked, 1'b0);
        tick(1);
        check("R7 locked after wait", locked, 1'b1);
        lock = 1'b0;
        tick(1);
        check("R7 lock flag low", locked, 1'b0);
        lock = 1'b1;
        tick(1);
        check("R7 lock flag back", locked, 1'b1);
    endtask

    task automatic t_pll_path();
        pclk_t = 1'b1; pclk_c = 1'b0;
        tick(1);
        check("R6 sel", byp_sel, 1'b0);
        check("R6 outs hi", {out_t, out_c, fb_t, fb_c}, {{NUM_OUT{1'b1}}, {NUM_OUT{1'b0}}, 2'b10});
        pclk_t = 1'b0; pclk_c = 1'b1;
        tick(1);
        check("R6 outs lo", {out_t, out_c, fb_t, fb_c}, {{NUM_OUT{1'b0}}, {NUM_OUT{1'b1}}, 2'b01});
        check("R4 on controls", ctl(), 4'b1111);
    endtask

    task automatic t_hyst_on();
        half_ns = 40;
        tick(SETTLE);
        check("R5 mid rate keeps on", mode, 2'b00);
    endtask

    task automatic t_low_freq();
        half_ns = 100;
        tick(SETTLE);
        check("R3 slow enters lp", mode, 2'b11);
        check("R3 lp controls", {ctl(), |out_oe}, 5'b0);
        check("R8 locked cleared", locked, 1'b0);
        half_ns = 40;
        tick(SETTLE);
        check("R5 mid rate keeps lp", mode, 2'b11);
    endtask

    task automatic t_return();
        int guard = 0;
        half_ns = 20;
        do begin
            tick(1);
            guard++;
        end while (mode != 2'b00 && guard < SETTLE);
        check("R4 clock return", mode, 2'b00);
        check("R8 restart no lock", locked, 1'b0);
        check("R4 controls back", ctl(), 4'b1111);
    endtask

    task automatic t_powerdown();
        pd_n  = 1'b0;
        strap = 1'b1;
        tick(5);
        check("R1 pd over strap", mode, 2'b10);
        check("R1 pd controls", {ctl(), |out_oe}, 5'b0);
        check("R8 locked off in pd", locked, 1'b0);
    endtask

    task automatic t_bypass();
        half_ns = 100;
        pd_n = 1'b1;
        tick(SETTLE);
        check("R2 bypass over low freq", mode, 2'b01);
        run_in = 1'b0;
        tick(2);
        in_t = 1'b1; in_c = 1'b0;
        tick(1);
        check("R2 ctl", {pll_en, rx_en, byp_sel, &out_oe, fb_oe}, 5'b01111);
        check("R2 route 10", {out_t, out_c, fb_t, fb_c}, {{NUM_OUT{1'b1}}, {NUM_OUT{1'b0}}, 2'b10});
        in_t = 1'b0; in_c = 1'b1;
        tick(1);
        check("R2 route 01", {out_t, out_c, fb_t, fb_c}, {{NUM_OUT{1'b0}}, {NUM_OUT{1'b1}}, 2'b01});
        in_t = 1'b1; in_c = 1'b1;
        tick(1);
        check("R2 legs independent", {out_t, out_c, fb_t, fb_c}, {{NUM_OUT{1'b1}}, {NUM_OUT{1'b1}}, 2'b11});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lock_wait();
        t_pll_path();
        t_hyst_on();
        t_low_freq();
        t_return();
        t_powerdown();
        t_bypass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule